// File: doc/BRIEF.md
# Packed Horizontal Pairwise Adder

This block is a SIMD datapath that adds each element to its neighbour within one operand vector. It does not add across operands. It takes two packed source vectors, sums each adjacent even/odd element pair inside each source, and packs all the sums into one result vector. Inside every 128-bit group, the sums from the first source sit in the lower half of the group and the sums from the second source sit in the upper half. Within each half the sums are in ascending pair order.

Elements are either 16 bits or 32 bits wide. Every sum wraps modulo the element width, and the block produces no carry or overflow indication. There are four operating forms, and they differ in how wide the vector is and what happens to the destination bits above the active width:

- A narrow 64-bit form.
- A 128-bit form that keeps the old upper destination bits.
- A 128-bit form that clears the upper destination bits.
- A 256-bit form that runs two independent 128-bit groups.

For the 128-bit form that keeps the upper bits, a second operand fetched from memory must be 16-byte aligned. If it is not, the operation raises a fault instead of producing a result. A result appears one clock after the start strobe.

Top module: `hadd_pack`

## Requirements
- R1: Each result element is the wrapped sum of elements 2k and 2k+1 of a single source. In each 128-bit group (or in the 64-bit vector in the narrow form), the first source's sums fill the lower half in ascending k and the second source's sums fill the upper half in ascending k.
- R2: With `esz_i`=0 the elements are 16 bits wide.
- R3: With `esz_i`=1 the elements are 32 bits wide.
- R4: Sums wrap modulo 2^element width. For 16-bit elements, 0x8000+0x8000 gives 0x0000 and 0x7FFF+0x0001 gives 0x8000. For 32-bit elements, 0x80000000+0x80000000 gives 0 and 0x7FFFFFFF+1 gives 0x80000000.
- R5: `form_i`=0 (narrow) uses only bits 63:0 of both sources, and result bits 255:64 are zero.
- R6: `form_i`=1 (128-bit, keep) computes bits 127:0 and copies bits 255:128 from `dst_old_i`.
- R7: `form_i`=2 (128-bit, clear) computes bits 127:0 and clears bits 255:128.
- R8: `form_i`=3 (256-bit) computes bits 127:0 and bits 255:128 as two independent groups. No pair spans bit 127/128.
- R9: `fault_o` pulses one cycle after `start_i` exactly when `form_i`=1, `b_mem_i`=1 and `b_addr_i[3:0]`≠0. In that cycle `valid_o` stays low and `result_o` keeps its previous value. The same misaligned address raises no fault in any other form or when `b_mem_i`=0.
- R10: `valid_o` is high in the cycle after a non-faulting `start_i`, for one cycle per start. Without a start, `valid_o` is low and `result_o` holds.
- R11: While `rst_n` is low, `result_o` is zero and `valid_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation with the present inputs |
| esz_i | input | 1 | Element size: 0 = 16-bit, 1 = 32-bit |
| form_i | input | 2 | 0 narrow 64, 1 128 keep upper, 2 128 clear upper, 3 256 |
| src_a_i | input | 256 | First source vector |
| src_b_i | input | 256 | Second source vector |
| dst_old_i | input | 256 | Previous destination contents |
| b_mem_i | input | 1 | Second source was read from memory |
| b_addr_i | input | 32 | Byte address of the memory operand |
| result_o | output | 256 | Registered packed result |
| valid_o | output | 1 | Result strobe, one cycle |
| fault_o | output | 1 | Alignment fault strobe, one cycle |

## Verification
The bench builds the block with its default parameters: a 128-bit group, a 64-bit narrow form, 32-bit addresses and a 16-byte alignment check. With these values all four forms, both element sizes and every nonzero value of the low four address bits are reachable. Random operands in every form and size are mixed with directed wrap-around pairs, a 256-bit case with distinct values on either side of bit 128, and a misaligned address presented in the forms where it must be ignored.

// File: rtl/hadd_pkg.sv
package hadd_pkg;

   typedef enum logic [1:0] {
      FM_NARROW  = 2'd0,
      FM_KEEP128 = 2'd1,
      FM_ZERO128 = 2'd2,
      FM_FULL256 = 2'd3
   } form_e;

   localparam int EW_NARROW = 16;
   localparam int EW_WIDE   = 32;

endpackage

// File: rtl/hadd_group.sv
module hadd_group #(
   parameter int GW   = 128,
   parameter int EW_N = hadd_pkg::EW_NARROW,
   parameter int EW_W = hadd_pkg::EW_WIDE
) (
   input  logic [GW-1:0] a_i,
   input  logic [GW-1:0] b_i,
   input  logic          wide_i,
   output logic [GW-1:0] sum_o
);
   localparam int NP_N = GW / (2 * EW_N);
   localparam int NP_W = GW / (2 * EW_W);

   if (GW % (2 * EW_W) != 0 || GW % (2 * EW_N) != 0) begin : g_bad_width
      $error("hadd_group: GW must hold whole element pairs");
   end

   logic [GW-1:0] sum_n;
   logic [GW-1:0] sum_w;

   for (genvar i = 0; i < NP_N; i++) begin : g_pair_n
      assign sum_n[i*EW_N +: EW_N] =
         a_i[2*i*EW_N +: EW_N] + a_i[(2*i+1)*EW_N +: EW_N];
      assign sum_n[(NP_N+i)*EW_N +: EW_N] =
         b_i[2*i*EW_N +: EW_N] + b_i[(2*i+1)*EW_N +: EW_N];
   end

   for (genvar j = 0; j < NP_W; j++) begin : g_pair_w
      assign sum_w[j*EW_W +: EW_W] =
         a_i[2*j*EW_W +: EW_W] + a_i[(2*j+1)*EW_W +: EW_W];
      assign sum_w[(NP_W+j)*EW_W +: EW_W] =
         b_i[2*j*EW_W +: EW_W] + b_i[(2*j+1)*EW_W +: EW_W];
   end

   assign sum_o = wide_i ? sum_w : sum_n;

   always_comb begin
      if (!wide_i)
         AST_GROUP_PAIR0: assert (sum_o[EW_N-1:0] == EW_N'(a_i[EW_N-1:0] + a_i[2*EW_N-1:EW_N])); // R1
   end
endmodule

// File: rtl/hadd_align.sv
module hadd_align #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_LOG2 = 4
) (
   input  logic              chk_en_i,
   input  logic              mem_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              bad_o
);
   if (ALIGN_LOG2 < 1 || ALIGN_LOG2 >= ADDR_W) begin : g_bad_align
      $error("hadd_align: ALIGN_LOG2 out of range");
   end

   assign bad_o = chk_en_i & mem_i & (|addr_i[ALIGN_LOG2-1:0]);
endmodule

// File: rtl/hadd_pack.sv
module hadd_pack #(
   parameter int GROUP_W    = 128,
   parameter int NARROW_W   = 64,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 esz_i,
   input  logic [1:0]           form_i,
   input  logic [2*GROUP_W-1:0] src_a_i,
   input  logic [2*GROUP_W-1:0] src_b_i,
   input  logic [2*GROUP_W-1:0] dst_old_i,
   input  logic                 b_mem_i,
   input  logic [ADDR_W-1:0]    b_addr_i,
   output logic [2*GROUP_W-1:0] result_o,
   output logic                 valid_o,
   output logic                 fault_o
);
   import hadd_pkg::*;

   localparam int VEC_W = 2 * GROUP_W;
   localparam int NGRP  = VEC_W / GROUP_W;

   if (GROUP_W != 2 * NARROW_W) begin : g_bad_group
      $error("hadd_pack: GROUP_W must be twice NARROW_W");
   end
   if (NARROW_W % (2 * EW_WIDE) != 0) begin : g_bad_narrow
      $error("hadd_pack: NARROW_W must hold whole wide pairs");
   end

   form_e form;
   assign form = form_e'(form_i);

   logic [NARROW_W-1:0]  nar_sum;
   logic [GROUP_W-1:0]   grp_sum [NGRP];
   logic [VEC_W-1:0]     next_res;
   logic                 bad_align;

   hadd_group #(.GW(NARROW_W)) u_narrow (
      .a_i   (src_a_i[NARROW_W-1:0]),
      .b_i   (src_b_i[NARROW_W-1:0]),
      .wide_i(esz_i),
      .sum_o (nar_sum)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_group
      hadd_group #(.GW(GROUP_W)) u_grp (
         .a_i   (src_a_i[g*GROUP_W +: GROUP_W]),
         .b_i   (src_b_i[g*GROUP_W +: GROUP_W]),
         .wide_i(esz_i),
         .sum_o (grp_sum[g])
      );
   end

   hadd_align #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_align (
      .chk_en_i(form == FM_KEEP128),
      .mem_i   (b_mem_i),
      .addr_i  (b_addr_i),
      .bad_o   (bad_align)
   );

   always_comb begin
      unique case (form)
         FM_NARROW:  next_res = {{(VEC_W-NARROW_W){1'b0}}, nar_sum};
         FM_KEEP128: next_res = {dst_old_i[VEC_W-1:GROUP_W], grp_sum[0]};
         FM_ZERO128: next_res = {{GROUP_W{1'b0}}, grp_sum[0]};
         default:    next_res = {grp_sum[1], grp_sum[0]};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         valid_o  <= 1'b0;
         fault_o  <= 1'b0;
      end else begin
         valid_o <= start_i & ~bad_align;
         fault_o <= start_i & bad_align;
         if (start_i && !bad_align) result_o <= next_res;
      end
   end

   AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(start_i)); // R10
   AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && fault_o)); // R9
   AST_FAULT_HOLDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $stable(result_o)); // R9
   AST_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> ($past(form_i) == 2'd1 && $past(b_mem_i))); // R9
   AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(form_i) == 2'd1) |->
         result_o[VEC_W-1:GROUP_W] == $past(dst_old_i[VEC_W-1:GROUP_W])); // R6
   AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(form_i) == 2'd2) |-> result_o[VEC_W-1:GROUP_W] == '0); // R7
   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(form_i) == 2'd0) |-> result_o[VEC_W-1:NARROW_W] == '0); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start_i) |-> (!valid_o && $stable(result_o))); // R10
endmodule

// File: tb/hadd_pack_test.sv
module hadd_pack_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         esz_i = 1'b0;
   logic [1:0]   form_i = 2'd0;
   logic [255:0] src_a_i = '0;
   logic [255:0] src_b_i = '0;
   logic [255:0] dst_old_i = '0;
   logic         b_mem_i = 1'b0;
   logic [31:0]  b_addr_i = '0;
   logic [255:0] result_o;
   logic         valid_o;
   logic         fault_o;

   int checks = 0;
   int failures = 0;
   logic [255:0] last_res = '0;

   always #4 clk = ~clk;

   hadd_pack uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .esz_i(esz_i),
      .form_i(form_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .dst_old_i(dst_old_i), .b_mem_i(b_mem_i), .b_addr_i(b_addr_i),
      .result_o(result_o), .valid_o(valid_o), .fault_o(fault_o)
   );

   function automatic logic [127:0] grp(input logic [127:0] a, input logic [127:0] b,
                                        input int gw, input bit wide);
      int ew = wide ? 32 : 16;
      int np = gw / (2 * ew);
      logic [127:0] mask = (128'd1 << ew) - 128'd1;
      logic [127:0] r = '0;
      for (int i = 0; i < np; i++) begin
         logic [127:0] xa = a >> (2 * i * ew);
         logic [127:0] xb = b >> (2 * i * ew);
         logic [127:0] sa = ((xa & mask) + ((xa >> ew) & mask)) & mask;
         logic [127:0] sb = ((xb & mask) + ((xb >> ew) & mask)) & mask;
         r = r | (sa << (i * ew)) | (sb << ((np + i) * ew));
      end
      return r;
   endfunction

   function automatic logic [255:0] model(input logic [1:0] f, input bit wide,
                                          input logic [255:0] a, input logic [255:0] b,
                                          input logic [255:0] d);
      logic [127:0] lo = grp(a[127:0], b[127:0], 128, wide);
      logic [127:0] hi = grp(a[255:128], b[255:128], 128, wide);
      logic [127:0] nr = grp({64'd0, a[63:0]}, {64'd0, b[63:0]}, 64, wide);
      case (f)
         2'd0:    return {192'd0, nr[63:0]};
         2'd1:    return {d[255:128], lo};
         2'd2:    return {128'd0, lo};
         default: return {hi, lo};
      endcase
   endfunction

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk(input string rq, input logic [255:0] got, input logic [255:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", rq, got, exp);
      end
   endtask

   task automatic run_op(input string rq, input logic [1:0] f, input bit wide,
                         input logic [255:0] a, input logic [255:0] b, input logic [255:0] d,
                         input bit mem, input logic [31:0] addr);
      bit bad = (f == 2'd1) && mem && (addr[3:0] != 4'd0);
      logic [255:0] exp = bad ? last_res : model(f, wide, a, b, d);
      @(negedge clk);
      start_i = 1'b1; form_i = f; esz_i = wide; src_a_i = a; src_b_i = b;
      dst_old_i = d; b_mem_i = mem; b_addr_i = addr;
      @(negedge clk);
      start_i = 1'b0;
      chk({rq, " valid"}, {255'd0, valid_o}, {255'd0, !bad});
      chk({rq, " fault R9"}, {255'd0, fault_o}, {255'd0, bad});
      chk({rq, " result"}, result_o, exp);
      last_res = exp;
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [255:0] a, b, d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 result", result_o, '0);
      chk("R11 valid", {255'd0, valid_o}, '0);
      chk("R11 fault", {255'd0, fault_o}, '0);
      rst_n = 1'b1;

      // R1 R2 ordering with distinct small words
      for (int k = 0; k < 16; k++) begin a[k*16 +: 16] = 16'(k + 1); b[k*16 +: 16] = 16'(100 + k); end
      d = rnd256();
      run_op("R1 R2 form256", 2'd3, 1'b0, a, b, d, 1'b0, 32'd0);
      run_op("R3 form256", 2'd3, 1'b1, a, b, d, 1'b0, 32'd0);
      // R4 wrap cases
      a = {16{16'h8000}}; b = {8{16'h0001, 16'h7FFF}};
      run_op("R4 16-bit wrap", 2'd3, 1'b0, a, b, d, 1'b0, 32'd0);
      a = {8{32'h8000_0000}}; b = {4{32'h0000_0001, 32'h7FFF_FFFF}};
      run_op("R4 32-bit wrap", 2'd3, 1'b1, a, b, d, 1'b0, 32'd0);
      // R5 narrow ignores upper bits
      a = rnd256(); b = rnd256();
      run_op("R5 narrow", 2'd0, 1'b0, a, b, d, 1'b0, 32'd0);
      run_op("R6 keep", 2'd1, 1'b1, a, b, d, 1'b1, 32'h1000);
      run_op("R7 clear", 2'd2, 1'b0, a, b, d, 1'b0, 32'd0);
      // R8 distinct values straddling bit 128
      a = '0; a[127:112] = 16'h1111; a[143:128] = 16'h2222; b = '0;
      run_op("R8 boundary", 2'd3, 1'b0, a, b, d, 1'b0, 32'd0);
      // R9 fault and non-fault misalignment
      run_op("R9 fault", 2'd1, 1'b0, rnd256(), rnd256(), d, 1'b1, 32'h0000_1008);
      run_op("R9 no-mem", 2'd1, 1'b0, rnd256(), rnd256(), d, 1'b0, 32'h0000_1008);
      run_op("R9 other form", 2'd2, 1'b1, rnd256(), rnd256(), d, 1'b1, 32'h0000_1003);
      // R10 idle cycle: no valid, result holds
      @(negedge clk);
      chk("R10 idle valid", {255'd0, valid_o}, '0);
      chk("R10 idle hold", result_o, last_res);

      for (int n = 0; n < 300; n++) begin
         logic [31:0] ad = $urandom;
         if ($urandom % 2 == 0) ad[3:0] = 4'd0;
         run_op("R1 random", 2'($urandom), 1'($urandom), rnd256(), rnd256(), rnd256(),
                1'($urandom), ad);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule